// File: doc/BRIEF.md
# SPI Nonvolatile-SRAM Command Controller

This block is the serial slave front end of a byte-wide nonvolatile SRAM. It takes SPI transactions (chip select, serial clock, serial in), decodes an 8-bit instruction and carries out the matching operation. It can read and write the byte array with a self-advancing address, and it can read and write a small status register. It handles the write-enable latch and the eight-byte serial number, and it returns a fixed device identifier. For the nonvolatile side it issues single-cycle request pulses: save to the nonvolatile cells, restore from them, turn automatic save on or off, and enter sleep. The cell technology itself sits outside this block. It reports back through a single completion strobe, and that strobe clears a busy bit in the status register.

All SPI pins are resynchronised into the system clock domain and their edges are detected there. Inputs are taken on rising serial-clock edges, and the output moves on falling edges. Either clock idle level therefore works (modes 0 and 3). Memory writes pass through three gates: the write-enable latch, a two-bit block protection field covering the top quarter, the top half or the whole array, and a write-protect pin that can lock the status register. The logical address space is 17 bits wide. The behavioural storage keeps only the low `RAM_AW` address bits, so logical addresses that share those bits alias to one location.

Top module: `spi_nvsram_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the serial output enable is low, and no request pulse has been issued.
- R2: `spi_so_oe` is low whenever chip select is high. Input bits are taken on rising SCK and output bits change on falling SCK, so transfers work with SCK idling low (mode 0) or high (mode 3). Bytes travel MSB first.
- R3: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it. While the latch is clear, memory writes, status writes and serial-number writes have no effect.
- R4: Read (0x03) is followed by three address bytes, of which only the low 17 bits count. Data starts in the very next byte. The address advances by one per byte and wraps from 0x1FFFF to 0x00000.
- R5: Write (0x02) is followed by three address bytes and then data bytes. Each data byte is stored at the current address, and the address then advances with the same wrap as reads.
- R6: Fast read (0x0B) behaves like read but sends one dummy byte (0x00) between the address and the first data byte.
- R7: Status read (0x05) returns the status byte in every following byte. Status write (0x01) updates only bit 7 (pin-protect enable) and bits 3:2 (block protect) from its first data byte. Bit 0 (busy) and bit 1 (write-enable latch) are read-only, and the other bits read 0.
- R8: When status bit 7 is 1 and `wp_n` is low, a status write is ignored. With `wp_n` high it takes effect.
- R9: Block protect 01 guards addresses whose bits 16:15 are 11, 10 guards addresses whose bit 16 is 1, and 11 guards the whole array. Data bytes aimed at a guarded address are dropped, while the address still advances.
- R10: Serial-number write (0xC2) stores successive data bytes into entries 0..7. Serial-number read (0xC3) returns entries 0..7 in order and then starts again at entry 0.
- R11: ID read (0x9F) returns the 4-byte `DEV_ID` most significant byte first, repeating after the last byte.
- R12: When chip select rises after opcode 0x3C (save) or 0x60 (restore) with the latch set, a one-cycle pulse goes out on `store_req` or `recall_req` and status bit 0 becomes 1 until `nv_done`. Opcodes 0x59, 0x19 and 0xB9 pulse `autostore_en_req`, `autostore_dis_req` and `sleep_req` without needing the latch.
- R13: When chip select rises on a byte boundary after a write, status-write, serial-number-write, save or restore command, the write-enable latch clears.
- R14: If chip select rises with a partial byte shifted in, that partial byte is discarded. No request pulse is issued and the latch is not cleared, while bytes completed earlier in the command stay in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output enable for the serial data pad |
| wp_n | input | 1 | Write-protect pin, active low |
| nv_done | input | 1 | Completion strobe for save or restore |
| store_req | output | 1 | One-cycle save request |
| recall_req | output | 1 | One-cycle restore request |
| autostore_en_req | output | 1 | One-cycle automatic-save enable request |
| autostore_dis_req | output | 1 | One-cycle automatic-save disable request |
| sleep_req | output | 1 | One-cycle sleep request |

## Verification
The assertions rely on a few properties of the inputs. Every serial-clock phase must last well beyond the synchroniser depth. Chip select must never change within a few system cycles of an SCK edge. `nv_done` must arrive only while a save or restore is pending. The bench drives every pin on the falling system-clock edge and holds each SCK phase for eight system cycles. It keeps chip select steady for eight cycles on each side of a transaction and pulses `nv_done` only after it has seen the busy bit set.

// File: rtl/spinv_pkg.sv
`timescale 1ns/1ps
package spinv_pkg;

  localparam logic [7:0] CMD_SR_WR   = 8'h01;
  localparam logic [7:0] CMD_MEM_WR  = 8'h02;
  localparam logic [7:0] CMD_MEM_RD  = 8'h03;
  localparam logic [7:0] CMD_WE_OFF  = 8'h04;
  localparam logic [7:0] CMD_SR_RD   = 8'h05;
  localparam logic [7:0] CMD_WE_ON   = 8'h06;
  localparam logic [7:0] CMD_MEM_FRD = 8'h0B;
  localparam logic [7:0] CMD_ID_RD   = 8'h9F;
  localparam logic [7:0] CMD_SN_WR   = 8'hC2;
  localparam logic [7:0] CMD_SN_RD   = 8'hC3;
  localparam logic [7:0] CMD_SAVE    = 8'h3C;
  localparam logic [7:0] CMD_RESTORE = 8'h60;
  localparam logic [7:0] CMD_AUTO_ON = 8'h59;
  localparam logic [7:0] CMD_AUTO_OFF= 8'h19;
  localparam logic [7:0] CMD_DOZE    = 8'hB9;

  typedef struct packed {
    logic save;
    logic restore;
    logic auto_on;
    logic auto_off;
    logic doze;
  } nv_req_t;

  // Block protect decode on the two top address bits.
  function automatic logic in_guard(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b01:   in_guard = (top2 == 2'b11);
      2'b10:   in_guard = top2[1];
      2'b11:   in_guard = 1'b1;
      default: in_guard = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spinv_sync.sv
`timescale 1ns/1ps
module spinv_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[gi] <= RST_VAL;
          else        stg[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[gi] <= RST_VAL;
          else        stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spinv_status.sv
`timescale 1ns/1ps
module spinv_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       sr_we,
  input  logic       sr_wpen_d,
  input  logic [1:0] sr_bp_d,
  input  logic       nv_start,
  input  logic       nv_done,
  input  logic       wp_n,
  output logic [7:0] sr,
  output logic       wel,
  output logic [1:0] bp,
  output logic       wpen,
  output logic       busy
);

  logic       wel_n, wpen_n, busy_n;
  logic [1:0] bp_n;

  always_comb begin
    wel_n  = wel;
    wpen_n = wpen;
    bp_n   = bp;
    busy_n = busy;
    if (wel_set)      wel_n = 1'b1;
    else if (wel_clr) wel_n = 1'b0;
    if (sr_we) begin
      wpen_n = sr_wpen_d;
      bp_n   = sr_bp_d;
    end
    if (nv_start)     busy_n = 1'b1;
    else if (nv_done) busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      wpen <= 1'b0;
      bp   <= 2'b00;
      busy <= 1'b0;
    end else begin
      wel  <= wel_n;
      wpen <= wpen_n;
      bp   <= bp_n;
      busy <= busy_n;
    end
  end

  assign sr = {wpen, 3'b000, bp, wel, busy};

  assert_sr_we_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |-> wel);

  assert_wp_pin_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && wpen) |-> wp_n);

  assert_busy_after_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |=> busy);

  assert_busy_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_done && !nv_start) |=> !busy);

  assert_wel_drops_R13: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |=> !wel);

endmodule

// File: rtl/spinv_store.sv
`timescale 1ns/1ps
module spinv_store #(
  parameter int RAM_AW   = 10,
  parameter int SN_BYTES = 8,
  parameter int SEQ_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_we,
  input  logic [RAM_AW-1:0] mem_waddr,
  input  logic [7:0]        mem_wdata,
  input  logic [RAM_AW-1:0] mem_raddr,
  output logic [7:0]        mem_rdata,
  input  logic              sn_we,
  input  logic [SEQ_W-1:0]  sn_idx,
  input  logic [7:0]        sn_wdata,
  output logic [7:0]        sn_rdata
);

  localparam int DEPTH   = 1 << RAM_AW;
  localparam int SN_SLOT = 1 << SEQ_W;

  logic [7:0] ram [DEPTH];
  logic [7:0] sn  [SN_SLOT];

  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_waddr] <= mem_wdata;
  end

  assign mem_rdata = ram[mem_raddr];

  genvar gs;
  generate
    for (gs = 0; gs < SN_SLOT; gs++) begin : g_sn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   sn[gs] <= 8'h00;
        else if (sn_we && (sn_idx == SEQ_W'(gs)))     sn[gs] <= sn_wdata;
      end
    end
  endgenerate

  assign sn_rdata = sn[sn_idx];

  assert_sn_index_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sn_we |-> (int'(sn_idx) < SN_BYTES));

endmodule

// File: rtl/spi_nvsram_ctrl.sv
`timescale 1ns/1ps
module spi_nvsram_ctrl
  import spinv_pkg::*;
#(
  parameter int                    ADDR_W      = 17,
  parameter int                    RAM_AW      = 10,
  parameter int                    SN_BYTES    = 8,
  parameter int                    ID_BYTES    = 4,
  parameter logic [8*ID_BYTES-1:0] DEV_ID      = 32'h4A1C0E57,
  parameter int                    SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_si,
  output logic spi_so,
  output logic spi_so_oe,
  input  logic wp_n,
  input  logic nv_done,
  output logic store_req,
  output logic recall_req,
  output logic autostore_en_req,
  output logic autostore_dis_req,
  output logic sleep_req
);

  localparam int SEQ_MAX   = (SN_BYTES > ID_BYTES) ? SN_BYTES : ID_BYTES;
  localparam int SEQ_W     = (SEQ_MAX > 2) ? $clog2(SEQ_MAX) : 1;
  localparam int SEQ_SLOT  = 1 << SEQ_W;
  localparam int BYTE_W    = 3;
  localparam int ADDR_LAST = 3;
  localparam logic [SEQ_W-1:0] SN_LAST = SEQ_W'(SN_BYTES - 1);
  localparam logic [SEQ_W-1:0] ID_LAST = SEQ_W'(ID_BYTES - 1);

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_core;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core = rst_pipe[1];

  // Pin synchronisers: {wp_n, si, sck, cs_n}
  logic [3:0] pin_q;
  spinv_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk   (clk),
    .rst_n (rst_core),
    .d     ({wp_n, spi_si, spi_sck, spi_cs_n}),
    .q     (pin_q)
  );

  logic cs_s, sck_s, si_s, wp_s;
  assign cs_s  = pin_q[0];
  assign sck_s = pin_q[1];
  assign si_s  = pin_q[2];
  assign wp_s  = pin_q[3];

  // State registers
  logic              cs_prev, sck_prev;
  logic [2:0]        bit_cnt,  bit_n;
  logic [BYTE_W-1:0] byte_cnt, byte_n;
  logic [6:0]        rx_sh,    rx_n;
  logic [7:0]        opcode,   op_n;
  logic [ADDR_W-1:0] addr,     addr_n;
  logic [7:0]        tx_sh,    tx_n;
  logic [SEQ_W-1:0]  seq,      seq_n;
  nv_req_t           req_q,    req_n;

  logic cs_act, cs_end, sck_rise, sck_fall;
  assign cs_act   = !cs_s;
  assign cs_end   = cs_s && !cs_prev;
  assign sck_rise = cs_act && sck_s && !sck_prev;
  assign sck_fall = cs_act && !sck_s && sck_prev;

  // Status and storage interfaces
  logic       wel_set, wel_clr, sr_we, nv_start;
  logic [7:0] sr;
  logic       wel, wpen, busy;
  logic [1:0] bp;
  logic       mem_we, sn_we;
  logic [7:0] mem_rdata, sn_rdata, rx_byte;

  assign rx_byte  = {rx_sh, si_s};
  assign nv_start = req_n.save || req_n.restore;

  // Device identifier bytes, most significant first.
  logic [7:0] id_tab [SEQ_SLOT];
  genvar gi;
  generate
    for (gi = 0; gi < SEQ_SLOT; gi++) begin : g_id
      if (gi < ID_BYTES) begin : g_live
        assign id_tab[gi] = DEV_ID[8*(ID_BYTES-1-gi) +: 8];
      end else begin : g_pad
        assign id_tab[gi] = 8'h00;
      end
    end
  endgenerate

  logic byte_last;
  assign byte_last = (bit_cnt == 3'd7);

  always_comb begin
    bit_n   = bit_cnt;
    byte_n  = byte_cnt;
    rx_n    = rx_sh;
    op_n    = opcode;
    addr_n  = addr;
    tx_n    = tx_sh;
    seq_n   = seq;
    req_n   = '0;
    wel_set = 1'b0;
    wel_clr = 1'b0;
    sr_we   = 1'b0;
    mem_we  = 1'b0;
    sn_we   = 1'b0;

    if (!cs_act) begin
      bit_n  = '0;
      byte_n = '0;
      seq_n  = '0;
      tx_n   = '0;
      if (cs_end && (bit_cnt == 3'd0) && (byte_cnt != '0)) begin
        case (opcode)
          CMD_MEM_WR, CMD_SR_WR, CMD_SN_WR: wel_clr = 1'b1;
          CMD_SAVE: begin
            req_n.save = wel;
            wel_clr    = 1'b1;
          end
          CMD_RESTORE: begin
            req_n.restore = wel;
            wel_clr       = 1'b1;
          end
          CMD_AUTO_ON:  req_n.auto_on  = 1'b1;
          CMD_AUTO_OFF: req_n.auto_off = 1'b1;
          CMD_DOZE:     req_n.doze     = 1'b1;
          default: ;
        endcase
      end
    end else if (sck_rise) begin
      bit_n = bit_cnt + 3'd1;
      rx_n  = rx_byte[6:0];
      if (byte_last) begin
        if (byte_cnt != '1) byte_n = byte_cnt + 1'b1;
        if (byte_cnt == '0) begin
          op_n = rx_byte;
          if (rx_byte == CMD_WE_ON)  wel_set = 1'b1;
          if (rx_byte == CMD_WE_OFF) wel_clr = 1'b1;
        end else begin
          case (opcode)
            CMD_MEM_RD, CMD_MEM_FRD, CMD_MEM_WR: begin
              if (int'(byte_cnt) <= ADDR_LAST) begin
                addr_n = {addr[ADDR_W-9:0], rx_byte};
              end else if (opcode == CMD_MEM_WR) begin
                mem_we = wel && !in_guard(bp, addr[ADDR_W-1 -: 2]);
                addr_n = addr + 1'b1;
              end
            end
            CMD_SR_WR: begin
              if (byte_cnt == BYTE_W'(1)) sr_we = wel && !(wpen && !wp_s);
            end
            CMD_SN_WR: begin
              sn_we = wel;
              seq_n = (seq == SN_LAST) ? '0 : seq + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end else if (sck_fall) begin
      if ((bit_cnt == 3'd0) && (byte_cnt != '0)) begin
        tx_n = 8'h00;
        case (opcode)
          CMD_SR_RD: tx_n = sr;
          CMD_MEM_RD: begin
            if (int'(byte_cnt) > ADDR_LAST) begin
              tx_n   = mem_rdata;
              addr_n = addr + 1'b1;
            end
          end
          CMD_MEM_FRD: begin
            if (int'(byte_cnt) > ADDR_LAST + 1) begin
              tx_n   = mem_rdata;
              addr_n = addr + 1'b1;
            end
          end
          CMD_SN_RD: begin
            tx_n  = sn_rdata;
            seq_n = (seq == SN_LAST) ? '0 : seq + 1'b1;
          end
          CMD_ID_RD: begin
            tx_n  = id_tab[seq];
            seq_n = (seq == ID_LAST) ? '0 : seq + 1'b1;
          end
          default: ;
        endcase
      end else begin
        tx_n = {tx_sh[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sh    <= '0;
      opcode   <= '0;
      addr     <= '0;
      tx_sh    <= '0;
      seq      <= '0;
      req_q    <= '0;
    end else begin
      cs_prev  <= cs_s;
      sck_prev <= sck_s;
      bit_cnt  <= bit_n;
      byte_cnt <= byte_n;
      rx_sh    <= rx_n;
      opcode   <= op_n;
      addr     <= addr_n;
      tx_sh    <= tx_n;
      seq      <= seq_n;
      req_q    <= req_n;
    end
  end

  spinv_status u_status (
    .clk       (clk),
    .rst_n     (rst_core),
    .wel_set   (wel_set),
    .wel_clr   (wel_clr),
    .sr_we     (sr_we),
    .sr_wpen_d (rx_byte[7]),
    .sr_bp_d   (rx_byte[3:2]),
    .nv_start  (nv_start),
    .nv_done   (nv_done),
    .wp_n      (wp_s),
    .sr        (sr),
    .wel       (wel),
    .bp        (bp),
    .wpen      (wpen),
    .busy      (busy)
  );

  spinv_store #(.RAM_AW(RAM_AW), .SN_BYTES(SN_BYTES), .SEQ_W(SEQ_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_core),
    .mem_we    (mem_we),
    .mem_waddr (addr[RAM_AW-1:0]),
    .mem_wdata (rx_byte),
    .mem_raddr (addr[RAM_AW-1:0]),
    .mem_rdata (mem_rdata),
    .sn_we     (sn_we),
    .sn_idx    (seq),
    .sn_wdata  (rx_byte),
    .sn_rdata  (sn_rdata)
  );

  assign spi_so            = tx_sh[7];
  assign spi_so_oe         = cs_act;
  assign store_req         = req_q.save;
  assign recall_req        = req_q.restore;
  assign autostore_en_req  = req_q.auto_on;
  assign autostore_dis_req = req_q.auto_off;
  assign sleep_req         = req_q.doze;

  assert_single_request_R12: assert property (@(posedge clk) disable iff (!rst_core)
    $onehot0(req_q));

  assert_abort_no_request_R14: assert property (@(posedge clk) disable iff (!rst_core)
    (cs_end && (bit_cnt != 3'd0)) |=> (req_q == '0));

  assert_mem_write_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_core)
    mem_we |-> wel);

endmodule

// File: tb/sim_spi_nvsram_ctrl.sv
`timescale 1ns/1ps
module sim_spi_nvsram_ctrl;

  localparam int HALF = 8;
  localparam logic [31:0] ID = 32'h4A1C0E57;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cs_n, sck, si, wp_n, nv_done;
  logic so, so_oe, st_r, rc_r, ae_r, ad_r, sl_r;

  spi_nvsram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe), .wp_n(wp_n), .nv_done(nv_done),
    .store_req(st_r), .recall_req(rc_r), .autostore_en_req(ae_r),
    .autostore_dis_req(ad_r), .sleep_req(sl_r)
  );

  int n_cmp = 0, n_bad = 0;
  int c_st = 0, c_rc = 0, c_ae = 0, c_ad = 0, c_sl = 0, c_wide = 0;
  logic [4:0] req_prev = '0;

  always @(posedge clk) begin
    if (st_r) c_st++;
    if (rc_r) c_rc++;
    if (ae_r) c_ae++;
    if (ad_r) c_ad++;
    if (sl_r) c_sl++;
    if ((req_prev & {st_r, rc_r, ae_r, ad_r, sl_r}) != 5'b0) c_wide++;
    req_prev <= {st_r, rc_r, ae_r, ad_r, sl_r};
  end

  logic [7:0] tb_tx [0:15];
  logic [7:0] tb_rx [0:15];
  logic [7:0] got   [0:11];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, input bit m3, output logic r);
    if (m3) sck = 1'b0;
    si = b;
    tick(HALF);
    r = so;
    sck = 1'b1;
    tick(HALF);
    if (!m3) sck = 1'b0;
  endtask

  task automatic spi_cmd(input int nbytes, input int extra, input bit m3);
    logic r;
    sck = m3;
    tick(4);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbytes; i++) begin
      for (int b = 7; b >= 0; b--) begin
        shift_bit(tb_tx[i][b], m3, r);
        tb_rx[i][b] = r;
      end
    end
    for (int b = 7; b > 7 - extra; b--) shift_bit(tb_tx[nbytes][b], m3, r);
    tick(HALF);
    cs_n = 1'b1;
    tick(3 * HALF);
  endtask

  task automatic op1(input logic [7:0] op);
    tb_tx[0] = op;
    spi_cmd(1, 0, 1'b0);
  endtask

  task automatic rdsr(output logic [7:0] v);
    tb_tx[0] = 8'h05; tb_tx[1] = 8'h00; tb_tx[2] = 8'h00;
    spi_cmd(3, 0, 1'b0);
    v = tb_rx[1];
  endtask

  task automatic wrsr(input logic [7:0] v);
    tb_tx[0] = 8'h01; tb_tx[1] = v;
    spi_cmd(2, 0, 1'b0);
  endtask

  task automatic mem_wr(input logic [23:0] a, input int n, input int extra);
    tb_tx[0] = 8'h02; tb_tx[1] = a[23:16]; tb_tx[2] = a[15:8]; tb_tx[3] = a[7:0];
    for (int i = 0; i <= n; i++) tb_tx[4+i] = got[i];
    spi_cmd(4 + n, extra, 1'b0);
  endtask

  task automatic mem_rd(input logic [23:0] a, input int n, input bit m3, input bit fast);
    tb_tx[0] = fast ? 8'h0B : 8'h03;
    tb_tx[1] = a[23:16]; tb_tx[2] = a[15:8]; tb_tx[3] = a[7:0];
    for (int i = 4; i < 16; i++) tb_tx[i] = 8'h00;
    spi_cmd(4 + int'(fast) + n, 0, m3);
    for (int i = 0; i < n; i++) got[i] = tb_rx[4 + int'(fast) + i];
  endtask

  function automatic logic guarded(input logic [1:0] bp, input logic [16:0] a);
    case (bp)
      2'b01:   return a[16:15] == 2'b11;
      2'b10:   return a[16];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    check("R1 oe after reset", 32'(so_oe), 32'h0);
    rdsr(v);
    check("R1 status after reset", 32'(v), 32'h00);
    check("R1 no requests", 32'(c_st + c_rc + c_ae + c_ad + c_sl), 32'h0);
    cs_n = 1'b0; tick(HALF);
    check("R2 oe with cs low", 32'(so_oe), 32'h1);
    cs_n = 1'b1; tick(HALF);
    check("R2 oe with cs high", 32'(so_oe), 32'h0);
  endtask

  task automatic t_wel_write;
    logic [7:0] v;
    op1(8'h06); rdsr(v);
    check("R3 latch set", 32'(v), 32'h02);
    op1(8'h04); rdsr(v);
    check("R3 latch clear", 32'(v), 32'h00);
    op1(8'h06);
    got[0] = 8'hA5; mem_wr(24'h000010, 1, 0);
    rdsr(v);
    check("R13 latch cleared after write", 32'(v), 32'h00);
    mem_rd(24'h000010, 1, 1'b0, 1'b0);
    check("R5 single byte write", 32'(got[0]), 32'hA5);
    got[0] = 8'h5A; mem_wr(24'h000010, 1, 0);
    mem_rd(24'h000010, 1, 1'b0, 1'b0);
    check("R3 write without latch ignored", 32'(got[0]), 32'hA5);
  endtask

  task automatic t_burst;
    op1(8'h06);
    got[0] = 8'h11; got[1] = 8'h22; got[2] = 8'h33;
    mem_wr(24'h01FFFE, 3, 0);
    mem_rd(24'h01FFFE, 3, 1'b1, 1'b0);
    check("R4 R2 mode3 burst byte0", 32'(got[0]), 32'h11);
    check("R4 mode3 burst byte1", 32'(got[1]), 32'h22);
    check("R4 R5 wrap to zero", 32'(got[2]), 32'h33);
    mem_rd(24'hFE0000, 1, 1'b0, 1'b0);
    check("R4 upper address bits ignored", 32'(got[0]), 32'h33);
    mem_rd(24'h01FFFE, 2, 1'b0, 1'b1);
    check("R6 fast read byte0", 32'(got[0]), 32'h11);
    check("R6 fast read byte1", 32'(got[1]), 32'h22);
  endtask

  task automatic t_status;
    logic [7:0] v;
    op1(8'h06); wrsr(8'h8F);
    tb_tx[0] = 8'h05; tb_tx[1] = 8'h00; tb_tx[2] = 8'h00;
    spi_cmd(3, 0, 1'b0);
    check("R7 writable bits only", 32'(tb_rx[1]), 32'h8C);
    check("R7 status repeats", 32'(tb_rx[2]), 32'h8C);
    wp_n = 1'b0; tick(4);
    op1(8'h06); wrsr(8'h00); rdsr(v);
    check("R8 pin blocks status write", 32'(v), 32'h8C);
    wp_n = 1'b1; tick(4);
    op1(8'h06); wrsr(8'h00); rdsr(v);
    check("R8 pin released", 32'(v), 32'h00);
    wrsr(8'h0C); rdsr(v);
    check("R3 status write without latch", 32'(v), 32'h00);
  endtask

  task automatic t_protect;
    logic [16:0] pa [0:2];
    logic [7:0]  ex [0:2];
    logic [7:0]  v;
    pa[0] = 17'h00101; pa[1] = 17'h10102; pa[2] = 17'h18103;
    for (int k = 0; k < 3; k++) begin
      op1(8'h06); got[0] = 8'(k + 1); mem_wr({7'd0, pa[k]}, 1, 0); ex[k] = 8'(k + 1);
    end
    for (int b = 1; b < 4; b++) begin
      op1(8'h06); wrsr(8'(b << 2)); rdsr(v);
      check("R9 protect field set", 32'(v), 32'(b << 2));
      for (int k = 0; k < 3; k++) begin
        op1(8'h06); got[0] = 8'(8'hE0 + b * 16 + k); mem_wr({7'd0, pa[k]}, 1, 0);
        if (!guarded(2'(b), pa[k])) ex[k] = 8'(8'hE0 + b * 16 + k);
      end
      for (int k = 0; k < 3; k++) begin
        mem_rd({7'd0, pa[k]}, 1, 1'b0, 1'b0);
        check("R9 guarded write", 32'(got[0]), 32'(ex[k]));
      end
    end
    op1(8'h06); wrsr(8'h00);
  endtask

  task automatic t_serial;
    op1(8'h06);
    tb_tx[0] = 8'hC2;
    for (int i = 0; i < 8; i++) tb_tx[1+i] = 8'(8'h30 + i);
    spi_cmd(9, 0, 1'b0);
    tb_tx[0] = 8'hC3;
    for (int i = 1; i < 12; i++) tb_tx[i] = 8'h00;
    spi_cmd(11, 0, 1'b1);
    for (int i = 0; i < 10; i++) check("R10 serial number read", 32'(tb_rx[1+i]), 32'(8'h30 + (i % 8)));
    tb_tx[0] = 8'hC2;
    for (int i = 0; i < 8; i++) tb_tx[1+i] = 8'hFF;
    spi_cmd(9, 0, 1'b0);
    tb_tx[0] = 8'hC3; tb_tx[1] = 8'h00;
    spi_cmd(2, 0, 1'b0);
    check("R3 serial write without latch", 32'(tb_rx[1]), 32'h30);
  endtask

  task automatic t_ident;
    tb_tx[0] = 8'h9F;
    for (int i = 1; i < 6; i++) tb_tx[i] = 8'h00;
    spi_cmd(6, 0, 1'b0);
    for (int i = 0; i < 5; i++) check("R11 id byte", 32'(tb_rx[1+i]), 32'(ID[8*(3-(i%4)) +: 8]));
  endtask

  task automatic t_nv;
    logic [7:0] v;
    op1(8'h3C);
    check("R12 save needs latch", 32'(c_st), 32'h0);
    op1(8'h06); op1(8'h3C);
    check("R12 save pulse", 32'(c_st), 32'h1);
    rdsr(v);
    check("R12 R13 busy set latch cleared", 32'(v), 32'h01);
    nv_done = 1'b1; tick(1); nv_done = 1'b0; tick(2);
    rdsr(v);
    check("R12 busy cleared", 32'(v), 32'h00);
    op1(8'h06); op1(8'h60);
    check("R12 restore pulse", 32'(c_rc), 32'h1);
    nv_done = 1'b1; tick(1); nv_done = 1'b0; tick(2);
    op1(8'h59); op1(8'h19); op1(8'hB9);
    check("R12 auto on pulse", 32'(c_ae), 32'h1);
    check("R12 auto off pulse", 32'(c_ad), 32'h1);
    check("R12 sleep pulse", 32'(c_sl), 32'h1);
    check("R12 pulses one cycle", 32'(c_wide), 32'h0);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    op1(8'h06);
    tb_tx[0] = 8'h3C; tb_tx[1] = 8'hFF;
    spi_cmd(1, 3, 1'b0);
    check("R14 no pulse after abort", 32'(c_st), 32'h1);
    rdsr(v);
    check("R14 latch kept", 32'(v), 32'h02);
    got[0] = 8'h44; got[1] = 8'h66; mem_wr(24'h000200, 2, 0);
    op1(8'h06);
    got[0] = 8'h77; got[1] = 8'h88; mem_wr(24'h000200, 1, 4);
    rdsr(v);
    check("R14 latch kept after partial byte", 32'(v), 32'h02);
    mem_rd(24'h000200, 2, 1'b0, 1'b0);
    check("R14 completed byte kept", 32'(got[0]), 32'h77);
    check("R14 partial byte dropped", 32'(got[1]), 32'h66);
    op1(8'h04);
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; wp_n = 1'b1; nv_done = 1'b0;
    tick(6);
    rst_n = 1'b1;
    tick(6);
    t_reset;
    t_wel_write;
    t_burst;
    t_status;
    t_protect;
    t_serial;
    t_ident;
    t_nv;
    t_abort;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule